// File: doc/BRIEF.md
# Dual-Tap Image Line Reassembly Buffer

This block sits behind the deserializer of an area camera whose sensor is read out through two taps at once. The left tap delivers the left half of each line starting at the left edge and moving right. The right tap delivers the right half starting at the right edge and moving left. Each incoming sample is 10 bits wide, and only its 8 most significant bits are kept. The pixels of both taps, together with the frame-valid, line-valid and data-valid strobes, pass through the same register pipeline. Each tap is then written into its own dual-port RAM. The left RAM is filled at rising addresses and the right RAM at falling addresses, so that reading both RAMs upward returns the line in column order.

When a line ends, a reader walks the two RAMs and packs four pixels into each 32-bit word of an output FIFO. On the first line of each frame, the reader first pushes the latest range-sensor sample, with a flag bit set. This keeps each frame's distance reading in the stream just ahead of its image data. When the FIFO is at least half full, a transfer request to the downstream memory writer is raised. A push that finds the FIFO full is dropped and sets a sticky error bit.

The reader needs 2×HALF_LEN+3 cycles after a line ends. The line blanking of the camera must be longer than that. The default geometry is a 1608-column line, which gives HALF_LEN = 804.

Top module: `lrb_line_rebuild`

## Requirements
- R1: After reset, out_valid, fifo_level, xfer_req and ovf_err are all 0.
- R2: Only bits [9:2] of each 10-bit tap sample are stored; bits [1:0] have no effect on any output word.
- R3: Pixels and the frame, line and data strobes are delayed by the same three register stages, so a pixel is stored exactly when line-valid and data-valid sampled with it are high; a cycle with data-valid low inside a line stores nothing and does not advance the tap addresses.
- R4: A line is output in column order. Left-tap pixel i is column i. The first right-tap pixel of a line is column 2×HALF_LEN−1, and each following one is one column lower. Pixel word k holds columns 4k..4k+3, with the lowest column in bits [7:0], and has out_is_range = 0.
- R5: On the first line after each rising edge of frame-valid, one range word precedes the pixel words. It has out_is_range = 1, bits [23:0] equal to the last range sample captured with rng_valid, and bits [31:24] equal to 0.
- R6: Every other line produces no range word, and each line adds exactly 2×HALF_LEN/4 words.
- R7: Both tap address counters restart at each rising edge of line-valid. Every line therefore lands at the same addresses. More than HALF_LEN pixels per tap in one line are ignored.
- R8: xfer_req is 1 exactly when fifo_level is at least FIFO_DEPTH/2, and it changes on the same edge as fifo_level.
- R9: A push while fifo_level equals FIFO_DEPTH is dropped. The level and the stored words are unchanged, ovf_err is set, and ovf_err stays set until reset.
- R10: A pop on a non-empty FIFO gives out_valid = 1 one cycle later, with the oldest word on out_word and out_is_range. A pop on an empty FIFO gives out_valid = 0 and leaves fifo_level at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cam_fval | input | 1 | Frame-valid strobe from the camera |
| cam_lval | input | 1 | Line-valid strobe from the camera |
| cam_dval | input | 1 | Data-valid strobe from the camera |
| cam_tap_l | input | IN_W | Left-tap sample |
| cam_tap_r | input | IN_W | Right-tap sample |
| rng_valid | input | 1 | Capture strobe for the range sample |
| rng_data | input | RNG_W | Range sample |
| fifo_pop | input | 1 | Read request from the memory writer |
| out_valid | output | 1 | out_word and out_is_range hold a popped word |
| out_word | output | WORD_W | Popped data word |
| out_is_range | output | 1 | Popped word carries a range sample |
| fifo_level | output | $clog2(FIFO_DEPTH+1) | Words held in the output FIFO |
| xfer_req | output | 1 | FIFO at least half full |
| ovf_err | output | 1 | Sticky: a push was dropped on a full FIFO |

## Verification
A word pushed by the line reader and a full FIFO can meet in the same cycle. At that moment the request flag, the level and the overflow bit all have to settle consistently. The bench provokes this by holding off all pops, feeding lines until the FIFO is full, and then sending one more line. It judges the outcome by three things: the level stays pinned at the depth, ovf_err rises and stays set, and the drained contents are exactly the first lines' words with nothing from the dropped line.

// File: rtl/lrb_pkg.sv
package lrb_pkg;

  // line reader sequencing
  typedef enum logic [1:0] {
    RD_IDLE  = 2'd0,
    RD_RANGE = 2'd1,
    RD_PIX   = 2'd2
  } rd_state_e;

endpackage

// File: rtl/lrb_inpipe.sv
module lrb_inpipe #(
  parameter int W      = 8,
  parameter int STAGES = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] st [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_st
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) st[0] <= '0;
        else     st[0] <= d;
      end
    end else begin : g_rest
      always_ff @(posedge clk) begin
        if (rst) st[i] <= '0;
        else     st[i] <= st[i-1];
      end
    end
  end

  assign q = st[STAGES-1];

endmodule

// File: rtl/lrb_tap_ram.sv
module lrb_tap_ram #(
  parameter int DEPTH = 804,
  parameter int DW    = 8,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];

  // simple dual port, registered read
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/lrb_reader.sv
module lrb_reader
  import lrb_pkg::*;
#(
  parameter int HALF_LEN = 804,
  parameter int PIX_W    = 8,
  parameter int WORD_W   = 32,
  parameter int RNG_W    = 24,
  parameter int AW       = $clog2(HALF_LEN)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              with_range,
  input  logic [RNG_W-1:0]  rng_val,
  input  logic [PIX_W-1:0]  rd_l,
  input  logic [PIX_W-1:0]  rd_r,
  output logic [AW-1:0]     raddr,
  output logic              push,
  output logic [WORD_W:0]   push_word
);

  localparam int TOTAL = 2 * HALF_LEN;
  localparam int IW    = $clog2(TOTAL);
  localparam int LANES = WORD_W / PIX_W;
  localparam int LW    = (LANES > 1) ? $clog2(LANES) : 1;

  rd_state_e        st;
  logic [IW-1:0]    idx;
  logic             in_right;
  logic             v_q, sel_q;
  logic [LW-1:0]    lane;
  logic [WORD_W-1:0] acc;
  logic [PIX_W-1:0] pix;

  // both RAMs share one read address; the tap is picked one cycle later
  assign in_right = (idx >= IW'(HALF_LEN));
  always_comb raddr = in_right ? AW'(idx - IW'(HALF_LEN)) : AW'(idx);
  assign pix = sel_q ? rd_r : rd_l;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= RD_IDLE;
      idx       <= '0;
      v_q       <= 1'b0;
      sel_q     <= 1'b0;
      lane      <= '0;
      acc       <= '0;
      push      <= 1'b0;
      push_word <= '0;
    end else begin
      v_q   <= (st == RD_PIX);
      sel_q <= in_right;
      push  <= 1'b0;
      case (st)
        RD_IDLE: begin
          if (start) begin
            idx <= '0;
            st  <= with_range ? RD_RANGE : RD_PIX;
          end
        end
        RD_RANGE: begin
          push      <= 1'b1;
          push_word <= {1'b1, WORD_W'(rng_val)};
          st        <= RD_PIX;
        end
        RD_PIX: begin
          idx <= idx + 1'b1;
          if (idx == IW'(TOTAL - 1)) st <= RD_IDLE;
        end
        default: st <= RD_IDLE;
      endcase
      // pack pixels, first pixel ends in the low byte
      if (v_q) begin
        acc  <= {pix, acc[WORD_W-1:PIX_W]};
        lane <= lane + 1'b1;
        if (lane == LW'(LANES - 1)) begin
          push      <= 1'b1;
          push_word <= {1'b0, pix, acc[WORD_W-1:PIX_W]};
          lane      <= '0;
        end
      end
    end
  end

endmodule

// File: rtl/lrb_out_fifo.sv
module lrb_out_fifo #(
  parameter int DW    = 33,
  parameter int DEPTH = 16,
  parameter int PW    = $clog2(DEPTH),
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [DW-1:0] din,
  input  logic          pop,
  output logic [DW-1:0] dout,
  output logic          dvalid,
  output logic [CW-1:0] level,
  output logic          half,
  output logic          ovf
);

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic          do_push, do_pop;
  logic [CW-1:0] lvl_n;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    do_push = push && (level != CW'(DEPTH));
    do_pop  = pop && (level != '0);
    lvl_n   = level + CW'(do_push) - CW'(do_pop);
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (do_pop) dout <= mem[rp];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp     <= '0;
      rp     <= '0;
      level  <= '0;
      half   <= 1'b0;
      ovf    <= 1'b0;
      dvalid <= 1'b0;
    end else begin
      if (do_push) wp <= bump(wp);
      if (do_pop)  rp <= bump(rp);
      level  <= lvl_n;
      half   <= (lvl_n >= CW'(DEPTH / 2));
      ovf    <= ovf | (push & ~do_push);
      dvalid <= do_pop;
    end
  end

endmodule

// File: rtl/lrb_line_rebuild.sv
module lrb_line_rebuild
  import lrb_pkg::*;
#(
  parameter int HALF_LEN    = 804,
  parameter int IN_W        = 10,
  parameter int PIX_W       = 8,
  parameter int WORD_W      = 32,
  parameter int RNG_W       = 24,
  parameter int FIFO_DEPTH  = 16,
  parameter int PIPE_STAGES = 3
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             cam_fval,
  input  logic                             cam_lval,
  input  logic                             cam_dval,
  input  logic [IN_W-1:0]                  cam_tap_l,
  input  logic [IN_W-1:0]                  cam_tap_r,
  input  logic                             rng_valid,
  input  logic [RNG_W-1:0]                 rng_data,
  input  logic                             fifo_pop,
  output logic                             out_valid,
  output logic [WORD_W-1:0]                out_word,
  output logic                             out_is_range,
  output logic [$clog2(FIFO_DEPTH+1)-1:0]  fifo_level,
  output logic                             xfer_req,
  output logic                             ovf_err
);

  localparam int AW  = $clog2(HALF_LEN);
  localparam int CW1 = $clog2(HALF_LEN + 1);
  localparam int DW  = 1 + 2 * PIX_W;

  // ---------------- input alignment ----------------
  logic [1:0]    fl_s2, fl_s3;
  logic [DW-1:0] dp_q;
  logic          fv2, lv2, fv3, lv3, dv3;
  logic [PIX_W-1:0] pl, pr;

  lrb_inpipe #(.W(2), .STAGES(PIPE_STAGES - 1)) u_fl_pipe (
    .clk (clk),
    .rst (rst),
    .d   ({cam_fval, cam_lval}),
    .q   (fl_s2)
  );

  always_ff @(posedge clk) begin
    if (rst) fl_s3 <= '0;
    else     fl_s3 <= fl_s2;
  end

  lrb_inpipe #(.W(DW), .STAGES(PIPE_STAGES)) u_dp_pipe (
    .clk (clk),
    .rst (rst),
    .d   ({cam_dval, cam_tap_l[IN_W-1 -: PIX_W], cam_tap_r[IN_W-1 -: PIX_W]}),
    .q   (dp_q)
  );

  assign fv2 = fl_s2[1];
  assign lv2 = fl_s2[0];
  assign fv3 = fl_s3[1];
  assign lv3 = fl_s3[0];
  assign dv3 = dp_q[DW-1];
  assign pl  = dp_q[2*PIX_W-1:PIX_W];
  assign pr  = dp_q[PIX_W-1:0];

  // ---------------- tap write addressing ----------------
  logic [CW1-1:0] addr_l, addr_r;
  logic           wr_en;

  assign wr_en = lv3 & dv3 & (addr_l < CW1'(HALF_LEN));

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_l <= '0;
      addr_r <= CW1'(HALF_LEN - 1);
    end else if (lv2 & ~lv3) begin
      addr_l <= '0;
      addr_r <= CW1'(HALF_LEN - 1);
    end else if (wr_en) begin
      addr_l <= addr_l + 1'b1;
      addr_r <= addr_r - 1'b1;
    end
  end

  logic [AW-1:0]    waddr [2];
  logic [PIX_W-1:0] wdata [2];
  logic [PIX_W-1:0] rdata [2];
  logic [AW-1:0]    rd_addr;

  assign waddr[0] = AW'(addr_l);
  assign waddr[1] = AW'(addr_r);
  assign wdata[0] = pl;
  assign wdata[1] = pr;

  for (genvar t = 0; t < 2; t++) begin : g_tap
    lrb_tap_ram #(.DEPTH(HALF_LEN), .DW(PIX_W), .AW(AW)) u_ram (
      .clk   (clk),
      .we    (wr_en),
      .waddr (waddr[t]),
      .wdata (wdata[t]),
      .raddr (rd_addr),
      .rdata (rdata[t])
    );
  end

  // ---------------- line / frame sequencing ----------------
  logic             line_done, first_pend;
  logic [RNG_W-1:0] rng_hold;

  always_ff @(posedge clk) begin
    if (rst) begin
      line_done  <= 1'b0;
      first_pend <= 1'b0;
      rng_hold   <= '0;
    end else begin
      line_done <= lv3 & ~lv2;
      if (fv2 & ~fv3)     first_pend <= 1'b1;
      else if (line_done) first_pend <= 1'b0;
      if (rng_valid) rng_hold <= rng_data;
    end
  end

  logic              push;
  logic [WORD_W:0]   push_word;

  lrb_reader #(
    .HALF_LEN (HALF_LEN),
    .PIX_W    (PIX_W),
    .WORD_W   (WORD_W),
    .RNG_W    (RNG_W),
    .AW       (AW)
  ) u_reader (
    .clk        (clk),
    .rst        (rst),
    .start      (line_done),
    .with_range (first_pend),
    .rng_val    (rng_hold),
    .rd_l       (rdata[0]),
    .rd_r       (rdata[1]),
    .raddr      (rd_addr),
    .push       (push),
    .push_word  (push_word)
  );

  // ---------------- output FIFO ----------------
  logic [WORD_W:0] fifo_dout;

  lrb_out_fifo #(.DW(WORD_W + 1), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk    (clk),
    .rst    (rst),
    .push   (push),
    .din    (push_word),
    .pop    (fifo_pop),
    .dout   (fifo_dout),
    .dvalid (out_valid),
    .level  (fifo_level),
    .half   (xfer_req),
    .ovf    (ovf_err)
  );

  assign out_word     = fifo_dout[WORD_W-1:0];
  assign out_is_range = fifo_dout[WORD_W];

endmodule

// File: rtl/lrb_chk.sv
module lrb_chk #(
  parameter int DEPTH = 16,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          pop,
  input logic [CW-1:0] level,
  input logic          xfer_req,
  input logic          ovf,
  input logic          out_valid
);

  AST_REQ_HALF: assert property (@(posedge clk) disable iff (rst)
    xfer_req == (level >= CW'(DEPTH / 2))); // R8

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    ovf |=> ovf); // R9

  AST_LEVEL_CAP: assert property (@(posedge clk) disable iff (rst)
    level <= CW'(DEPTH)); // R9

  AST_FULL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (level == CW'(DEPTH) && !pop) |=> (level == CW'(DEPTH))); // R9

  AST_EMPTY_POP: assert property (@(posedge clk) disable iff (rst)
    (pop && level == '0) |=> !out_valid); // R10

  AST_POP_DATA: assert property (@(posedge clk) disable iff (rst)
    (pop && level != '0) |=> out_valid); // R10

endmodule

bind lrb_line_rebuild lrb_chk #(.DEPTH(FIFO_DEPTH)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .pop       (fifo_pop),
  .level     (fifo_level),
  .xfer_req  (xfer_req),
  .ovf       (ovf_err),
  .out_valid (out_valid)
);

// File: tb/sim_lrb_line_rebuild.sv
`timescale 1ns/1ps
module sim_lrb_line_rebuild;

  localparam int HL    = 4;
  localparam int DEPTH = 8;
  localparam int CW    = $clog2(DEPTH + 1);
  localparam int WPL   = 2 * HL / 4;
  localparam int NV    = 6;

  // {new_frame, dval_gap, seed[7:0], range[23:0]}
  localparam logic [33:0] TBL [NV] = '{
    {1'b1, 1'b0, 8'h10, 24'hA1B2C3},
    {1'b0, 1'b0, 8'h40, 24'h000111},
    {1'b0, 1'b1, 8'h7C, 24'h000222},
    {1'b1, 1'b1, 8'hF0, 24'h5A5A5A},
    {1'b1, 1'b0, 8'h00, 24'hFFFFFF},
    {1'b0, 1'b0, 8'hFE, 24'h123456}
  };

  logic clk = 1'b0;
  logic rst;
  logic cam_fval, cam_lval, cam_dval;
  logic [9:0] cam_tap_l, cam_tap_r;
  logic rng_valid;
  logic [23:0] rng_data;
  logic fifo_pop;
  logic out_valid;
  logic [31:0] out_word;
  logic out_is_range;
  logic [CW-1:0] fifo_level;
  logic xfer_req, ovf_err;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  lrb_line_rebuild #(.HALF_LEN(HL), .FIFO_DEPTH(DEPTH)) u0 (
    .clk(clk), .rst(rst),
    .cam_fval(cam_fval), .cam_lval(cam_lval), .cam_dval(cam_dval),
    .cam_tap_l(cam_tap_l), .cam_tap_r(cam_tap_r),
    .rng_valid(rng_valid), .rng_data(rng_data),
    .fifo_pop(fifo_pop),
    .out_valid(out_valid), .out_word(out_word), .out_is_range(out_is_range),
    .fifo_level(fifo_level), .xfer_req(xfer_req), .ovf_err(ovf_err)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_word(input logic [7:0] s, input int k);
    logic [31:0] w;
    for (int b = 0; b < 4; b++) w[8*b +: 8] = 8'(int'(s) + 4*k + b);
    return w;
  endfunction

  task automatic drive_line(input logic [7:0] s, input logic gap, input int extra);
    cam_lval = 1'b1;
    for (int c = 0; c < HL + extra; c++) begin
      if (gap && c == 1) begin
        cam_dval  = 1'b0;
        cam_tap_l = 10'h3FF;
        cam_tap_r = 10'h155;
        tick();
      end
      cam_dval  = 1'b1;
      cam_tap_l = {8'(int'(s) + c), 2'(c) ^ 2'b01};
      cam_tap_r = {8'(int'(s) + 2*HL - 1 - c), 2'(c + 1)};
      tick();
    end
    cam_dval = 1'b0;
    cam_lval = 1'b0;
    repeat (2*HL + 20) tick();
  endtask

  task automatic pop1(output logic v, output logic [31:0] w, output logic f);
    fifo_pop = 1'b1;
    tick();
    fifo_pop = 1'b0;
    v = out_valid;
    w = out_word;
    f = out_is_range;
  endtask

  task automatic run_entry(input logic [33:0] e);
    logic nf, gp, v, f;
    logic [7:0] s;
    logic [23:0] r;
    logic [31:0] w;
    nf = e[33]; gp = e[32]; s = e[31:24]; r = e[23:0];
    rng_data = r; rng_valid = 1'b1; tick(); rng_valid = 1'b0;
    if (nf) begin
      cam_fval = 1'b0; repeat (2) tick();
      cam_fval = 1'b1; repeat (2) tick();
    end
    drive_line(s, gp, 0);
    if (nf) begin
      pop1(v, w, f);
      chk("R5 range word valid", v, 1);
      chk("R5 range flag", f, 1);
      chk("R5 range word value", w, {8'h00, r});
    end
    for (int k = 0; k < WPL; k++) begin
      pop1(v, w, f);
      chk(gp ? "R3 word after dval gap" : "R2 R4 line word", w, exp_word(s, k));
      chk("R6 pixel word flag", f, 0);
    end
    chk("R6 no extra word", fifo_level, 0);
  endtask

  initial begin
    logic v, f;
    logic [31:0] w;
    logic [7:0] seeds [5];
    rst = 1'b1;
    cam_fval = 1'b0; cam_lval = 1'b0; cam_dval = 1'b0;
    cam_tap_l = '0; cam_tap_r = '0;
    rng_valid = 1'b0; rng_data = '0; fifo_pop = 1'b0;
    repeat (3) tick();
    rst = 1'b0;
    tick();
    chk("R1 reset out_valid", out_valid, 0);
    chk("R1 reset level", fifo_level, 0);
    chk("R1 reset xfer_req", xfer_req, 0);
    chk("R1 reset ovf_err", ovf_err, 0);

    // vector table walk
    for (int i = 0; i < NV; i++) run_entry(TBL[i]);

    // R7: excess pixels per tap are ignored; addresses restart per line
    drive_line(8'h33, 1'b0, 2);
    for (int k = 0; k < WPL; k++) begin
      pop1(v, w, f);
      chk("R7 word with excess pixels", w, exp_word(8'h33, k));
    end
    chk("R7 level after excess line", fifo_level, 0);

    // R8 / R9: fill without popping, then one line more
    for (int i = 0; i < 5; i++) begin
      int lvl;
      seeds[i] = 8'(8'h20 + 16*i);
      drive_line(seeds[i], 1'b0, 0);
      lvl = (2*(i+1) > DEPTH) ? DEPTH : 2*(i+1);
      chk("R8 level while filling", fifo_level, lvl);
      chk("R8 request vs level", xfer_req, (lvl >= DEPTH/2) ? 1 : 0);
      if (i < 4) chk("R9 no overflow before full", ovf_err, 0);
      else       chk("R9 overflow on full push", ovf_err, 1);
    end
    for (int j = 0; j < DEPTH; j++) begin
      pop1(v, w, f);
      if (j == 0) chk("R10 pop gives valid", v, 1);
      chk("R9 kept word after drop", w, exp_word(seeds[j/2], j%2));
      if (j == 4) chk("R8 request drops below half", xfer_req, 0);
    end
    chk("R9 overflow sticky", ovf_err, 1);
    chk("R9 level drained", fifo_level, 0);

    // R10: pop on empty
    pop1(v, w, f);
    chk("R10 empty pop no valid", v, 0);
    chk("R10 empty pop level", fifo_level, 0);

    // R1: reset clears sticky error
    rst = 1'b1; repeat (2) tick(); rst = 1'b0; tick();
    chk("R1 reset clears ovf_err", ovf_err, 0);
    chk("R1 reset clears xfer_req", xfer_req, 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog (all requirements) act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

endmodule